// File: doc/BRIEF.md
# Strobed Receiver Wake-Up Sequencer

This block sets the duty cycle of a low-power radio receiver. It alternates between an on phase and an off phase. Two programmable tick counters time the phases. They advance only on a timebase tick, a one-cycle pulse from a slow digital clock. Each unit of on time is `ON_UNIT` ticks (512 by default). Each unit of off time is `OFF_UNIT` ticks. A message that is still arriving when the on time runs out keeps the receiver on until the message ends.

An external strobe pin can override the counters. The pin has a level and a flag that says whether anything drives it. While the pin is driven high, the receiver is forced on. While it is driven low, the receiver is forced off. While the pin floats, the counters decide.

With bank alternation enabled, the block steps through bank A on, off, bank B on, off, and repeats, with no host involved. The bank select tells the receiver which configuration bank to load for the next on phase. The bank status bit reports the bank in use for the current or most recent on phase. Its value does not depend on which bank is read.

Top module: `wake_seq`

## Requirements
- R1: While synchronous reset is high, and on the first cycle after it, the receiver is off, the bank select is A (0) and the bank status is A (0).
- R2: An on phase started by the counters lasts exactly max(on_code,1) × ON_UNIT ticks when no message is in progress. The code 0 is treated as 1.
- R3: An off phase lasts exactly (off_code+1) × OFF_UNIT ticks. The off counter restarts from zero on every on-to-off transition.
- R4: Cycles without a tick do not advance either counter. With no ticks, the receiver state holds. With ticks on every other cycle, each phase takes twice as many clock cycles.
- R5: When the strobe is driven with level 1, the receiver is on from the next clock edge and stays on for as long as that holds, whatever the counters say.
- R6: When the strobe is driven with level 0, the receiver is off from the next clock edge and stays off for as long as that holds. This also overrides a message hold.
- R7: When the strobe is released, the counters start from zero in the phase the pin left. A release while forced off gives an off time of one tick less than R3 as seen from the release cycle, because the release cycle itself counts the first tick.
- R8: If msg_busy is high when the on time expires, the receiver stays on. It turns off at the first clock edge that sees msg_busy low.
- R9: With alt_en high, the bank select inverts on every on-to-off transition. The on phases after reset therefore use banks A, B, A, and so on.
- R10: With alt_en low, the bank select returns to A at the next clock edge and stays there.
- R11: The bank status takes the bank select value on each off-to-on transition and holds it for the whole on phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timebase tick, one cycle wide |
| strobe_drv | input | 1 | Strobe pin is driven (1) or floating (0) |
| strobe_lvl | input | 1 | Strobe pin level when driven |
| on_code | input | 4 | On time in units of ON_UNIT ticks (0 acts as 1) |
| off_code | input | 3 | Off time: (off_code+1) units of OFF_UNIT ticks |
| alt_en | input | 1 | Enable A/B bank alternation |
| msg_busy | input | 1 | A message is being received |
| rx_on | output | 1 | Receiver enable |
| bank_sel | output | 1 | Bank to load for the next on phase (0 = A, 1 = B) |
| bank_stat | output | 1 | Bank of the current or last on phase |

## Verification
Two functions can fall in the same cycle: the message hold, which keeps the receiver on, and a strobe driven low, which forces it off. The bench provokes this by holding msg_busy high well past expiry, so the block is in the held state, and then driving the pin low. The receiver must turn off at the very next edge, because the pin has priority. A second case is a strobe release that lands on a tick. The off counter must count that tick as the first one after restarting from zero, which the bench judges by an off time exactly one tick shorter than a normal off phase.

// File: rtl/wake_pkg.sv
package wake_pkg;

  typedef enum logic {PH_OFF = 1'b0, PH_ON = 1'b1} phase_t;

  // ticks in an on phase; code 0 is remapped to 1 so the cycle never stalls
  function automatic int unsigned on_ticks(input logic [3:0] code, input int unsigned unit);
    int unsigned n;
    n = (code == 4'd0) ? 1 : int'(code);
    return n * unit;
  endfunction

  // ticks in an off phase
  function automatic int unsigned off_ticks(input logic [2:0] code, input int unsigned unit);
    return (int'(code) + 1) * unit;
  endfunction

endpackage

// File: rtl/wake_len_sel.sv
module wake_len_sel
  import wake_pkg::*;
#(
  parameter int unsigned ON_UNIT  = 512,
  parameter int unsigned OFF_UNIT = 512,
  parameter int unsigned CW       = 14
) (
  input  logic [3:0]    on_code,
  input  logic [2:0]    off_code,
  output logic [CW-1:0] on_last,
  output logic [CW-1:0] off_last
);
  // terminal counts are length minus one
  always_comb begin
    on_last  = CW'(on_ticks(on_code, ON_UNIT) - 1);
    off_last = CW'(off_ticks(off_code, OFF_UNIT) - 1);
  end
endmodule

// File: rtl/wake_phase_ctrl.sv
module wake_phase_ctrl
  import wake_pkg::*;
#(
  parameter int unsigned CW = 14
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          pin_drv,
  input  logic          pin_lvl,
  input  logic          busy,
  input  logic [CW-1:0] on_last,
  input  logic [CW-1:0] off_last,
  output phase_t        phase,
  output logic          ev_on_start,
  output logic          ev_off_start,
  output logic          held
);
  logic [CW-1:0] cnt, cnt_nxt;
  phase_t        ph_nxt;

  // counter past the on terminal value means expired and waiting on a message
  assign held = (phase == PH_ON) && (cnt > on_last);

  always_comb begin
    ph_nxt  = phase;
    cnt_nxt = cnt;
    if (pin_drv) begin
      ph_nxt  = pin_lvl ? PH_ON : PH_OFF;
      cnt_nxt = '0;
    end else if (phase == PH_ON) begin
      if (held) begin
        if (!busy) begin
          ph_nxt  = PH_OFF;
          cnt_nxt = '0;
        end
      end else if (tick) begin
        if (cnt >= on_last) begin
          if (busy) begin
            cnt_nxt = on_last + 1'b1;
          end else begin
            ph_nxt  = PH_OFF;
            cnt_nxt = '0;
          end
        end else begin
          cnt_nxt = cnt + 1'b1;
        end
      end
    end else if (tick) begin
      if (cnt >= off_last) begin
        ph_nxt  = PH_ON;
        cnt_nxt = '0;
      end else begin
        cnt_nxt = cnt + 1'b1;
      end
    end
  end

  assign ev_on_start  = (phase == PH_OFF) && (ph_nxt == PH_ON);
  assign ev_off_start = (phase == PH_ON) && (ph_nxt == PH_OFF);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_OFF;
      cnt   <= '0;
    end else begin
      phase <= ph_nxt;
      cnt   <= cnt_nxt;
    end
  end
endmodule

// File: rtl/wake_bank_ctrl.sv
module wake_bank_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic alt_en,
  input  logic ev_on_start,
  input  logic ev_off_start,
  output logic bank_sel,
  output logic bank_stat
);
  always_ff @(posedge clk) begin
    if (rst) begin
      bank_sel  <= 1'b0;
      bank_stat <= 1'b0;
    end else begin
      if (!alt_en)           bank_sel <= 1'b0;
      else if (ev_off_start) bank_sel <= ~bank_sel;
      if (ev_on_start)       bank_stat <= bank_sel;
    end
  end
endmodule

// File: rtl/wake_seq.sv
module wake_seq
  import wake_pkg::*;
#(
  parameter int unsigned ON_UNIT  = 512,
  parameter int unsigned OFF_UNIT = 512
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       strobe_drv,
  input  logic       strobe_lvl,
  input  logic [3:0] on_code,
  input  logic [2:0] off_code,
  input  logic       alt_en,
  input  logic       msg_busy,
  output logic       rx_on,
  output logic       bank_sel,
  output logic       bank_stat
);
  localparam int unsigned ON_MAX  = 15 * ON_UNIT;
  localparam int unsigned OFF_MAX = 8 * OFF_UNIT;
  localparam int unsigned LEN_MAX = (ON_MAX > OFF_MAX) ? ON_MAX : OFF_MAX;
  localparam int unsigned CW      = $clog2(LEN_MAX + 2);

  logic [CW-1:0] on_last, off_last;
  phase_t        phase;
  logic          ev_on_start, ev_off_start, held;

  wake_len_sel #(.ON_UNIT(ON_UNIT), .OFF_UNIT(OFF_UNIT), .CW(CW)) u_len (
    .on_code  (on_code),
    .off_code (off_code),
    .on_last  (on_last),
    .off_last (off_last)
  );

  wake_phase_ctrl #(.CW(CW)) u_phase (
    .clk          (clk),
    .rst          (rst),
    .tick         (tick),
    .pin_drv      (strobe_drv),
    .pin_lvl      (strobe_lvl),
    .busy         (msg_busy),
    .on_last      (on_last),
    .off_last     (off_last),
    .phase        (phase),
    .ev_on_start  (ev_on_start),
    .ev_off_start (ev_off_start),
    .held         (held)
  );

  wake_bank_ctrl u_bank (
    .clk          (clk),
    .rst          (rst),
    .alt_en       (alt_en),
    .ev_on_start  (ev_on_start),
    .ev_off_start (ev_off_start),
    .bank_sel     (bank_sel),
    .bank_stat    (bank_stat)
  );

  assign rx_on = (phase == PH_ON);
endmodule

// File: rtl/wake_seq_chk.sv
module wake_seq_chk (
  input logic clk,
  input logic rst,
  input logic strobe_drv,
  input logic strobe_lvl,
  input logic alt_en,
  input logic msg_busy,
  input logic rx_on,
  input logic bank_sel,
  input logic bank_stat,
  input logic held,
  input logic ev_on_start
);
  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (!rx_on && !bank_sel && !bank_stat));

  assert_force_on_R5: assert property (@(posedge clk) disable iff (rst)
    (strobe_drv && strobe_lvl) |=> rx_on);

  assert_force_off_R6: assert property (@(posedge clk) disable iff (rst)
    (strobe_drv && !strobe_lvl) |=> !rx_on);

  assert_msg_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (rx_on && msg_busy && !strobe_drv) |=> rx_on);

  assert_hold_release_R8: assert property (@(posedge clk) disable iff (rst)
    (held && !msg_busy && !strobe_drv) |=> !rx_on);

  assert_bank_flip_R9: assert property (@(posedge clk) disable iff (rst)
    ($fell(rx_on) && $past(alt_en) && !$past(rst)) |-> (bank_sel != $past(bank_sel)));

  assert_bank_home_R10: assert property (@(posedge clk) disable iff (rst)
    !alt_en |=> !bank_sel);

  assert_stat_capture_R11: assert property (@(posedge clk) disable iff (rst)
    ev_on_start |=> (bank_stat == $past(bank_sel)));

  assert_stat_stable_R11: assert property (@(posedge clk) disable iff (rst)
    (rx_on && $past(rx_on) && !$past(rst)) |-> $stable(bank_stat));
endmodule

bind wake_seq wake_seq_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .strobe_drv  (strobe_drv),
  .strobe_lvl  (strobe_lvl),
  .alt_en      (alt_en),
  .msg_busy    (msg_busy),
  .rx_on       (rx_on),
  .bank_sel    (bank_sel),
  .bank_stat   (bank_stat),
  .held        (held),
  .ev_on_start (ev_on_start)
);

// File: tb/wake_seq_bench.sv
module wake_seq_bench;
  localparam int ON_UNIT  = 4;
  localparam int OFF_UNIT = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0;
  logic strobe_drv = 1'b0, strobe_lvl = 1'b0;
  logic [3:0] on_code = 4'd1;
  logic [2:0] off_code = 3'd0;
  logic alt_en = 1'b0, msg_busy = 1'b0;
  logic rx_on, bank_sel, bank_stat;

  int checks = 0;
  int failures = 0;
  int tick_mode = 1;  // 0 none, 1 every cycle, 2 every other cycle
  int cyc = 0;

  always #2 clk = ~clk;

  wake_seq #(.ON_UNIT(ON_UNIT), .OFF_UNIT(OFF_UNIT)) u_wake_seq (
    .clk(clk), .rst(rst), .tick(tick), .strobe_drv(strobe_drv), .strobe_lvl(strobe_lvl),
    .on_code(on_code), .off_code(off_code), .alt_en(alt_en), .msg_busy(msg_busy),
    .rx_on(rx_on), .bank_sel(bank_sel), .bank_stat(bank_stat)
  );

  always @(negedge clk) begin
    cyc <= cyc + 1;
    tick <= (tick_mode == 1) ? 1'b1 : (tick_mode == 2) ? cyc[0] : 1'b0;
  end

  initial begin
    #(4 * 150000);
    failures++;
    $display("FAIL watchdog expired act=%0d exp=0", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic wait_level(input logic v);
    for (int i = 0; i < 5000 && rx_on !== v; i++) @(negedge clk);
  endtask

  task automatic count_level(input logic v, output int n);
    n = 0;
    while (rx_on === v && n < 5000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(rx_on == 0 && bank_sel == 0 && bank_stat == 0, "R1 reset state",
        {rx_on, bank_sel, bank_stat}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(rx_on == 0 && bank_sel == 0, "R1 after reset", {rx_on, bank_sel}, 0);
  endtask

  task automatic t_on_len();
    int n;
    on_code = 4'd3; off_code = 3'd1;
    wait_level(0); wait_level(1); count_level(1, n);
    chk(n == 12, "R2 on length code 3", n, 12);
    on_code = 4'd0;
    wait_level(0); wait_level(1); count_level(1, n);
    chk(n == ON_UNIT, "R2 on length code 0 acts as 1", n, ON_UNIT);
  endtask

  task automatic t_off_len();
    int n;
    on_code = 4'd1; off_code = 3'd2;
    wait_level(1); wait_level(0); count_level(0, n);
    chk(n == 3 * OFF_UNIT, "R3 off length code 2", n, 3 * OFF_UNIT);
    off_code = 3'd0;
    wait_level(1); wait_level(0); count_level(0, n);
    chk(n == OFF_UNIT, "R3 off length code 0", n, OFF_UNIT);
  endtask

  task automatic t_tick();
    int n;
    int bad;
    logic v;
    tick_mode = 0;
    repeat (2) @(negedge clk);
    v = rx_on;
    bad = 0;
    repeat (40) begin
      @(negedge clk);
      if (rx_on !== v) bad++;
    end
    chk(bad == 0, "R4 no tick holds state", bad, 0);
    tick_mode = 2;
    on_code = 4'd1;
    wait_level(0); wait_level(1); count_level(1, n);
    chk(n == 2 * ON_UNIT, "R4 sparse ticks stretch on phase", n, 2 * ON_UNIT);
    tick_mode = 1;
  endtask

  task automatic t_force();
    int bad;
    int n;
    on_code = 4'd1; off_code = 3'd1;
    wait_level(0);
    strobe_drv = 1'b1; strobe_lvl = 1'b1;
    @(negedge clk);
    chk(rx_on == 1, "R5 forced on next edge", rx_on, 1);
    bad = 0;
    repeat (40) begin
      @(negedge clk);
      if (rx_on !== 1'b1) bad++;
    end
    chk(bad == 0, "R5 stays on past on time", bad, 0);
    strobe_lvl = 1'b0;
    @(negedge clk);
    chk(rx_on == 0, "R6 forced off next edge", rx_on, 1'b0);
    bad = 0;
    repeat (30) begin
      @(negedge clk);
      if (rx_on !== 1'b0) bad++;
    end
    chk(bad == 0, "R6 stays off past off time", bad, 0);
    strobe_drv = 1'b0;
    @(negedge clk);
    count_level(0, n);
    chk(n == 2 * OFF_UNIT - 1, "R7 off resumes from zero after release", n, 2 * OFF_UNIT - 1);
  endtask

  task automatic t_busy();
    int bad;
    on_code = 4'd1;
    wait_level(0);
    msg_busy = 1'b1;
    wait_level(1);
    bad = 0;
    repeat (30) begin
      @(negedge clk);
      if (rx_on !== 1'b1) bad++;
    end
    chk(bad == 0, "R8 on held while message busy", bad, 0);
    msg_busy = 1'b0;
    @(negedge clk);
    chk(rx_on == 0, "R8 off at edge after message end", rx_on, 0);
    // hold and forced low in the same cycle: the pin wins
    msg_busy = 1'b1;
    wait_level(1);
    repeat (10) @(negedge clk);
    strobe_drv = 1'b1; strobe_lvl = 1'b0;
    @(negedge clk);
    chk(rx_on == 0, "R6 forced low beats message hold", rx_on, 0);
    strobe_drv = 1'b0; msg_busy = 1'b0;
  endtask

  task automatic t_bank();
    int bad;
    do_reset();
    alt_en = 1'b1; on_code = 4'd1; off_code = 3'd0;
    wait_level(1);
    chk(bank_stat == 0, "R9 first on phase uses bank A", bank_stat, 0);
    bad = 0;
    while (rx_on === 1'b1 && bad < 100) begin
      if (bank_stat !== 1'b0) bad += 1000;
      bad++;
      @(negedge clk);
    end
    chk(bad < 1000, "R11 status stable through on phase", bad, ON_UNIT);
    chk(bank_sel == 1, "R9 select flips at on-to-off", bank_sel, 1);
    wait_level(1);
    chk(bank_stat == 1, "R9 second on phase uses bank B", bank_stat, 1);
    wait_level(0);
    chk(bank_sel == 0, "R9 select back to A", bank_sel, 0);
    wait_level(1);
    chk(bank_stat == 0, "R11 third on phase captures A", bank_stat, 0);
    wait_level(0);
    chk(bank_sel == 1, "R9 select B again", bank_sel, 1);
    alt_en = 1'b0;
    @(negedge clk);
    chk(bank_sel == 0, "R10 disable returns select to A", bank_sel, 0);
    wait_level(1); wait_level(0);
    chk(bank_sel == 0, "R10 select stays A while disabled", bank_sel, 0);
  endtask

  initial begin
    do_reset();
    t_on_len();
    t_off_len();
    t_tick();
    t_force();
    t_busy();
    t_bank();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule